// File: doc/BRIEF.md
# Registered AHB write bridge with early and merged responses

The bridge sits between an upstream AHB-Lite master and a downstream AHB-Lite slave and registers every transfer. This breaks the combinational timing path between them. Each upstream beat is replayed downstream as a single NONSEQ transfer, one at a time. For every write, the bridge decides whether the master may be released at once with an early OKAY, or must be held with wait states until the real downstream response is back. The decision uses the bufferable protection bit, the burst type and whether the beat is the last one of a defined-length burst.

Early OKAY for bufferable writes is allowed only when `cfg_early_ok` is set. This setting suits destinations that never refuse a write, such as plain RAM.

Non-bufferable bursts of defined length release every beat except the last without waiting for its response. The last beat is held until all downstream beats have finished, and it reports ERROR if any of them failed.

Undefined-length bursts and reads always wait for each beat's own real response.

Top module: `ahbwb_top`

## Requirements
- R1: After reset, `m_hreadyout` is 1, `m_hresp` is 0 and `s_htrans` is IDLE (2'b00).
- R2: A data phase that belongs to an IDLE (2'b00) or BUSY (2'b01) transfer completes with `m_hreadyout` 1 and `m_hresp` 0 in its first cycle, and starts no downstream transfer.
- R3: With `cfg_early_ok` = 1, a write with protection bit 2 set completes OKAY with zero wait states if the bridge is idle. The same address and data are still written downstream afterwards, even if that write gets ERROR there.
- R4: With `cfg_early_ok` = 0, a write with protection bit 2 set follows the non-bufferable rules and returns its real downstream response.
- R5: A non-bufferable SINGLE (`m_hburst` 3'b000) write holds `m_hreadyout` low for at least one cycle and returns the downstream response.
- R6: In a non-bufferable defined-length burst (`m_hburst` 3'b010..3'b111 = WRAP4, INCR4, WRAP8, INCR8, WRAP16, INCR16), every beat but the last is answered OKAY without waiting for its response. The last beat waits, and returns ERROR if any downstream beat of the burst got ERROR.
- R7: In a non-bufferable undefined-length INCR burst (`m_hburst` 3'b001), every beat waits and returns its own downstream response.
- R8: An ERROR to the master takes two cycles: first `m_hresp` 1 with `m_hreadyout` 0, then `m_hresp` 1 with `m_hreadyout` 1.
- R9: Reads always wait. They return the downstream read data and that beat's own response.
- R10: Each upstream beat is issued downstream exactly once, in order, as NONSEQ with its address held while `s_hready` is low. A downstream ERROR for a beat that was already answered never appears on the response of a different later transfer.
- R11: A BUSY inside a defined-length burst does not count as a beat, so the last-beat merge still lands on the true last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_early_ok | input | 1 | Allow early OKAY for bufferable writes |
| m_hsel | input | 1 | Upstream select |
| m_haddr | input | AW | Upstream address |
| m_htrans | input | 2 | Upstream transfer type |
| m_hwrite | input | 1 | Upstream write flag |
| m_hburst | input | 3 | Upstream burst type |
| m_hprot | input | 4 | Upstream protection; bit 2 = bufferable |
| m_hwdata | input | DW | Upstream write data |
| m_hready | input | 1 | Upstream bus ready in |
| m_hreadyout | output | 1 | Upstream ready out |
| m_hresp | output | 1 | Upstream response, 1 = ERROR |
| m_hrdata | output | DW | Upstream read data |
| s_htrans | output | 2 | Downstream transfer type |
| s_haddr | output | AW | Downstream address |
| s_hwrite | output | 1 | Downstream write flag |
| s_hprot | output | 4 | Downstream protection |
| s_hwdata | output | DW | Downstream write data |
| s_hready | input | 1 | Downstream ready |
| s_hresp | input | 1 | Downstream response, 1 = ERROR |
| s_hrdata | input | DW | Downstream read data |

## Verification
The hardest case to reach is an ERROR on a middle beat of a defined burst. That beat was already answered OKAY long ago, so its error must show up only on the final beat, and never on the transfer that follows.

The bench drives a downstream slave model that fails exactly one chosen address. It sweeps that address across every beat position, and a no-error case, for all six defined burst types at three downstream wait-state settings.

It also inserts a BUSY mid-burst to shift the beat count. And it follows an early-acknowledged failing write directly with a clean non-bufferable write.

// File: rtl/ahbwb_pkg.sv
package ahbwb_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic [2:0] BU_SINGLE = 3'd0;
    localparam logic [2:0] BU_INCR   = 3'd1;

    // Per-beat handling decided at address time.
    typedef struct packed {
        logic wr;     // write beat
        logic early;  // master released before downstream completes
        logic merge;  // response is the accumulated burst error
        logic first;  // NONSEQ: starts a fresh error accumulation
    } beat_cls_t;

    typedef enum logic [1:0] {EN_IDLE, EN_ADDR, EN_DATA, EN_DONE} eng_st_e;
    typedef enum logic [1:0] {PH_WAIT, PH_RUN, PH_ERR2} ph_st_e;

    // Beats that follow the first one for a defined-length burst.
    function automatic logic [3:0] beats_after_first(input logic [2:0] burst);
        case (burst)
            3'd2, 3'd3: return 4'd3;
            3'd4, 3'd5: return 4'd7;
            3'd6, 3'd7: return 4'd15;
            default:    return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/ahbwb_beat_track.sv
module ahbwb_beat_track
    import ahbwb_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       addr_take,
    input  logic [1:0] htrans,
    input  logic [2:0] hburst,
    input  logic       hwrite,
    input  logic       bufferable,
    input  logic       early_en,
    output beat_cls_t  cls
);
    logic [CW-1:0] left_q;
    logic          undef_q;
    logic          is_ns, is_seq, undef_now, last_now;

    always_comb begin
        is_ns     = (htrans == TR_NONSEQ);
        is_seq    = (htrans == TR_SEQ);
        undef_now = is_ns ? (hburst == BU_INCR) : undef_q;
        if (undef_now)
            last_now = 1'b0;
        else if (is_ns)
            last_now = (beats_after_first(hburst) == 4'd0);
        else
            last_now = (left_q == CW'(1));
        cls.wr    = hwrite;
        cls.first = is_ns;
        cls.merge = hwrite && !undef_now;
        cls.early = hwrite && ((bufferable && early_en) || (!undef_now && !last_now));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q  <= '0;
            undef_q <= 1'b0;
        end else if (addr_take && is_ns) begin
            left_q  <= CW'(beats_after_first(hburst));
            undef_q <= (hburst == BU_INCR);
        end else if (addr_take && is_seq && left_q != '0) begin
            left_q  <= left_q - CW'(1);
        end
    end

    assert_seq_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        (addr_take && is_seq && !undef_q) |-> (left_q != '0));

    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (addr_take && htrans == TR_BUSY) |=> $stable(left_q));

endmodule

// File: rtl/ahbwb_down_engine.sv
module ahbwb_down_engine
    import ahbwb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic          l_wr,
    input  logic [AW-1:0] l_addr,
    input  logic [3:0]    l_prot,
    input  logic [DW-1:0] l_wdata,
    input  logic          l_late,
    input  logic          l_first,
    input  logic          take,
    output logic          idle,
    output logic          done,
    output logic          own_err,
    output logic          acc_err,
    output logic [DW-1:0] rdata,
    output logic [1:0]    s_htrans,
    output logic [AW-1:0] s_haddr,
    output logic          s_hwrite,
    output logic [3:0]    s_hprot,
    output logic [DW-1:0] s_hwdata,
    input  logic          s_hready,
    input  logic          s_hresp,
    input  logic [DW-1:0] s_hrdata
);
    eng_st_e       st;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic [3:0]    prot_q;
    logic          wr_q, late_q, own_q, acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= EN_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            prot_q  <= '0;
            wr_q    <= 1'b0;
            late_q  <= 1'b0;
            own_q   <= 1'b0;
            acc_q   <= 1'b0;
        end else begin
            case (st)
                EN_IDLE: if (launch) begin
                    st      <= EN_ADDR;
                    addr_q  <= l_addr;
                    wdata_q <= l_wdata;
                    prot_q  <= l_prot;
                    wr_q    <= l_wr;
                    late_q  <= l_late;
                    if (l_first) acc_q <= 1'b0;
                end
                EN_ADDR: if (s_hready) st <= EN_DATA;
                EN_DATA: if (s_hready) begin
                    st      <= EN_DONE;
                    own_q   <= s_hresp;
                    acc_q   <= acc_q | s_hresp;
                    rdata_q <= s_hrdata;
                end
                EN_DONE: if (!late_q || take) st <= EN_IDLE;
                default: st <= EN_IDLE;
            endcase
        end
    end

    assign idle     = (st == EN_IDLE);
    assign done     = (st == EN_DONE) && late_q;
    assign own_err  = own_q;
    assign acc_err  = acc_q;
    assign rdata    = rdata_q;
    assign s_htrans = (st == EN_ADDR) ? TR_NONSEQ : TR_IDLE;
    assign s_haddr  = addr_q;
    assign s_hwrite = wr_q;
    assign s_hprot  = prot_q;
    assign s_hwdata = wdata_q;

    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (s_htrans == TR_NONSEQ && !s_hready) |=> (s_htrans == TR_NONSEQ && $stable(s_haddr)));

endmodule

// File: rtl/ahbwb_top.sv
module ahbwb_top
    import ahbwb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_early_ok,
    input  logic          m_hsel,
    input  logic [AW-1:0] m_haddr,
    input  logic [1:0]    m_htrans,
    input  logic          m_hwrite,
    input  logic [2:0]    m_hburst,
    input  logic [3:0]    m_hprot,
    input  logic [DW-1:0] m_hwdata,
    input  logic          m_hready,
    output logic          m_hreadyout,
    output logic          m_hresp,
    output logic [DW-1:0] m_hrdata,
    output logic [1:0]    s_htrans,
    output logic [AW-1:0] s_haddr,
    output logic          s_hwrite,
    output logic [3:0]    s_hprot,
    output logic [DW-1:0] s_hwdata,
    input  logic          s_hready,
    input  logic          s_hresp,
    input  logic [DW-1:0] s_hrdata
);
    beat_cls_t     cls_now, cls_r;
    logic          ph_act;
    logic [AW-1:0] addr_r;
    logic [3:0]    prot_r;
    ph_st_e        ph_st, ph_nx;
    logic          addr_take;
    logic          eng_launch, eng_late, eng_take;
    logic          eng_idle, eng_done, eng_own, eng_acc;

    assign addr_take = m_hsel && m_hready;

    ahbwb_beat_track #(.CW(CW)) u_track (
        .clk(clk), .rst(rst), .addr_take(addr_take), .htrans(m_htrans),
        .hburst(m_hburst), .hwrite(m_hwrite), .bufferable(m_hprot[2]),
        .early_en(cfg_early_ok), .cls(cls_now)
    );

    ahbwb_down_engine #(.AW(AW), .DW(DW)) u_eng (
        .clk(clk), .rst(rst), .launch(eng_launch), .l_wr(cls_r.wr),
        .l_addr(addr_r), .l_prot(prot_r), .l_wdata(m_hwdata), .l_late(eng_late),
        .l_first(cls_r.first), .take(eng_take), .idle(eng_idle), .done(eng_done),
        .own_err(eng_own), .acc_err(eng_acc), .rdata(m_hrdata),
        .s_htrans(s_htrans), .s_haddr(s_haddr), .s_hwrite(s_hwrite),
        .s_hprot(s_hprot), .s_hwdata(s_hwdata), .s_hready(s_hready),
        .s_hresp(s_hresp), .s_hrdata(s_hrdata)
    );

    always_comb begin
        m_hreadyout = 1'b1;
        m_hresp     = 1'b0;
        eng_launch  = 1'b0;
        eng_late    = 1'b0;
        eng_take    = 1'b0;
        ph_nx       = ph_st;
        if (ph_act) begin
            if (cls_r.early) begin
                m_hreadyout = eng_idle;
                eng_launch  = eng_idle;
            end else begin
                case (ph_st)
                    PH_WAIT: begin
                        m_hreadyout = 1'b0;
                        if (eng_idle) begin
                            eng_launch = 1'b1;
                            eng_late   = 1'b1;
                            ph_nx      = PH_RUN;
                        end
                    end
                    PH_RUN: begin
                        m_hreadyout = 1'b0;
                        if (eng_done) begin
                            eng_take = 1'b1;
                            if (cls_r.merge ? eng_acc : eng_own) begin
                                m_hresp = 1'b1;
                                ph_nx   = PH_ERR2;
                            end else begin
                                m_hreadyout = 1'b1;
                                ph_nx       = PH_WAIT;
                            end
                        end
                    end
                    PH_ERR2: begin
                        m_hresp = 1'b1;
                        ph_nx   = PH_WAIT;
                    end
                    default: ph_nx = PH_WAIT;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_act <= 1'b0;
            ph_st  <= PH_WAIT;
            cls_r  <= '0;
            addr_r <= '0;
            prot_r <= '0;
        end else begin
            ph_st <= ph_nx;
            if (m_hready) begin
                ph_act <= m_hsel && m_htrans[1];
                if (m_hsel && m_htrans[1]) begin
                    cls_r  <= cls_now;
                    addr_r <= m_haddr;
                    prot_r <= m_hprot;
                end
            end
        end
    end

    assert_err_two_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (m_hresp && !m_hreadyout) |=> (m_hresp && m_hreadyout));

    assert_done_has_owner_R10: assert property (@(posedge clk) disable iff (rst)
        eng_done |-> (ph_act && !cls_r.early && ph_st == PH_RUN));

endmodule

// File: tb/sim_ahbwb_top.sv
`timescale 1ns/1ps
module sim_ahbwb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_en = 1'b0;
    logic        m_hsel = 1'b0;
    logic [31:0] m_haddr = '0;
    logic [1:0]  m_htrans = 2'b00;
    logic        m_hwrite = 1'b0;
    logic [2:0]  m_hburst = 3'd0;
    logic [3:0]  m_hprot = 4'b0011;
    logic [31:0] m_hwdata = '0;
    logic        m_hreadyout, m_hresp;
    logic [31:0] m_hrdata;
    logic [1:0]  s_htrans;
    logic [31:0] s_haddr, s_hwdata, s_hrdata;
    logic        s_hwrite, s_hready, s_hresp;
    logic [3:0]  s_hprot;

    always #5 clk = ~clk;

    ahbwb_top u0 (
        .clk(clk), .rst(rst), .cfg_early_ok(cfg_en), .m_hsel(m_hsel),
        .m_haddr(m_haddr), .m_htrans(m_htrans), .m_hwrite(m_hwrite),
        .m_hburst(m_hburst), .m_hprot(m_hprot), .m_hwdata(m_hwdata),
        .m_hready(m_hreadyout), .m_hreadyout(m_hreadyout), .m_hresp(m_hresp),
        .m_hrdata(m_hrdata), .s_htrans(s_htrans), .s_haddr(s_haddr),
        .s_hwrite(s_hwrite), .s_hprot(s_hprot), .s_hwdata(s_hwdata),
        .s_hready(s_hready), .s_hresp(s_hresp), .s_hrdata(s_hrdata)
    );

    function automatic logic [31:0] wdat(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    // Downstream slave model: ws wait states, ERROR only at err_addr.
    int          ws = 0;
    logic [31:0] err_addr = 32'hFFFF_FFF0;
    logic        dp = 1'b0, dp_wr = 1'b0, dp_err = 1'b0, dp_e2 = 1'b0;
    logic [31:0] dp_addr = '0;
    int          dp_cnt = 0;
    int          dn_total = 0;
    int          wr_bad = 0;
    logic [31:0] log_addr [0:63];

    assign s_hready = !dp || (dp_cnt == 0 && (!dp_err || dp_e2));
    assign s_hresp  = dp && dp_cnt == 0 && dp_err;
    assign s_hrdata = dp_addr ^ 32'h5A5A_0000;

    always @(posedge clk) begin
        if (rst) begin
            dp <= 1'b0;
        end else begin
            if (dp) begin
                if (dp_cnt != 0) dp_cnt <= dp_cnt - 1;
                else if (dp_err && !dp_e2) dp_e2 <= 1'b1;
                else begin
                    dp <= 1'b0;
                    if (dp_wr && s_hwdata != wdat(dp_addr)) wr_bad <= wr_bad + 1;
                end
            end
            if (s_htrans == 2'b10 && s_hready) begin
                dp      <= 1'b1;
                dp_addr <= s_haddr;
                dp_wr   <= s_hwrite;
                dp_cnt  <= ws;
                dp_err  <= (s_haddr == err_addr);
                dp_e2   <= 1'b0;
                log_addr[dn_total % 64] <= s_haddr;
                dn_total <= dn_total + 1;
            end
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    logic        res_resp  [0:15];
    logic        res_form  [0:15];
    logic [31:0] res_rdata [0:15];
    int          res_wait  [0:15];
    int          busy_wait;

    task automatic run_seq(input int n, input logic wr, input logic [2:0] burst,
                           input logic p2, input logic [31:0] base, input int busy_before);
        int s_beat [0:17];
        int nslots;
        int k;
        int cur_s;
        int dph;
        int wcnt;
        bit pe;
        nslots = (busy_before > 0 && busy_before < n) ? n + 1 : n;
        k = 0;
        for (int s = 0; s < nslots; s++) begin
            if (nslots > n && s == busy_before) s_beat[s] = -1;
            else begin s_beat[s] = k; k++; end
        end
        cur_s = 0; dph = -2; wcnt = 0; pe = 0;
        while (cur_s < nslots || dph != -2) begin
            @(negedge clk);
            m_hsel = 1'b1;
            if (cur_s < nslots) begin
                if (s_beat[cur_s] < 0) m_htrans = 2'b01;
                else m_htrans = (s_beat[cur_s] == 0) ? 2'b10 : 2'b11;
                m_haddr  = base + 32'(4 * ((s_beat[cur_s] < 0) ? busy_before : s_beat[cur_s]));
                m_hwrite = wr;
                m_hburst = burst;
                m_hprot  = {1'b0, p2, 2'b11};
            end else begin
                m_htrans = 2'b00;
            end
            m_hwdata = (dph >= 0) ? wdat(base + 32'(4 * dph)) : 32'h0;
            #1;
            if (m_hreadyout) begin
                if (dph >= 0) begin
                    res_resp[dph]  = m_hresp;
                    res_rdata[dph] = m_hrdata;
                    res_wait[dph]  = wcnt;
                    res_form[dph]  = !m_hresp || pe;
                end else if (dph == -1) begin
                    busy_wait = wcnt;
                end
                if (cur_s < nslots) begin dph = s_beat[cur_s]; cur_s++; end
                else dph = -2;
                wcnt = 0; pe = 0;
            end else begin
                wcnt++;
                pe = m_hresp;
            end
        end
        @(negedge clk);
        m_htrans = 2'b00;
        repeat (15) @(negedge clk);
    endtask

    task automatic check_run(input string req, input int n, input logic wr,
                             input logic [2:0] burst, input logic p2,
                             input logic [31:0] base, input int busy_before);
        int d0;
        int bad0;
        bit defined;
        bit anyerr;
        d0 = dn_total; bad0 = wr_bad;
        defined = (burst != 3'd1);
        anyerr = 0;
        run_seq(n, wr, burst, p2, base, busy_before);
        for (int i = 0; i < n; i++) begin
            logic [31:0] a;
            bit e, early, expr;
            a = base + 32'(4 * i);
            e = (a == err_addr);
            early = wr && ((p2 && cfg_en) || (defined && i != n - 1));
            anyerr = anyerr | e;
            if (early) expr = 0;
            else if (wr && defined) expr = anyerr;
            else expr = e;
            chk(res_resp[i] == expr, req, $sformatf("beat %0d response", i),
                32'(res_resp[i]), 32'(expr));
            if (!early)
                chk(res_wait[i] >= 1, req, "wait states before real response",
                    32'(res_wait[i]), 32'd1);
            else if (i == 0)
                chk(res_wait[i] == 0, req, "early acceptance waits",
                    32'(res_wait[i]), 32'd0);
            if (expr)
                chk(res_form[i], "R8", "error preceded by stalled error cycle",
                    32'(res_form[i]), 32'd1);
            if (!wr && !expr)
                chk(res_rdata[i] == (a ^ 32'h5A5A_0000), "R9", "read data",
                    res_rdata[i], a ^ 32'h5A5A_0000);
        end
        chk(dn_total - d0 == n, "R10", "downstream beat count", 32'(dn_total - d0), 32'(n));
        for (int i = 0; i < n; i++)
            chk(log_addr[(d0 + i) % 64] == base + 32'(4 * i), "R10", "downstream address order",
                log_addr[(d0 + i) % 64], base + 32'(4 * i));
        if (wr) chk(wr_bad == bad0, req, "downstream write data", 32'(wr_bad - bad0), 32'd0);
    endtask

    function automatic int blen(input logic [2:0] b);
        case (b)
            3'd2, 3'd3: return 4;
            3'd4, 3'd5: return 8;
            default:    return 16;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(m_hreadyout == 1'b1, "R1", "reset ready", 32'(m_hreadyout), 32'd1);
        chk(m_hresp == 1'b0, "R1", "reset response", 32'(m_hresp), 32'd0);
        chk(s_htrans == 2'b00, "R1", "reset downstream trans", 32'(s_htrans), 32'd0);
        // R2: idle cycles stay ready and issue nothing downstream
        for (int c = 0; c < 8; c++) begin
            @(negedge clk); #1;
            chk(m_hreadyout && !m_hresp, "R2", "idle zero-wait OKAY",
                {30'd0, m_hresp, m_hreadyout}, 32'd1);
        end
        chk(dn_total == 0, "R2", "no downstream transfer while idle", 32'(dn_total), 32'd0);

        // R3: early OKAY, clean and failing destination
        cfg_en = 1'b1;
        err_addr = 32'h0000_0204;
        check_run("R3", 1, 1'b1, 3'd0, 1'b1, 32'h0000_0200, 0);
        check_run("R3", 1, 1'b1, 3'd0, 1'b1, 32'h0000_0204, 0);
        check_run("R3", 8, 1'b1, 3'd5, 1'b1, 32'h0000_01F8, 0);
        // R10: stale error never leaks into next transfer
        check_run("R10", 1, 1'b1, 3'd0, 1'b1, 32'h0000_0204, 0);
        check_run("R10", 1, 1'b1, 3'd0, 1'b0, 32'h0000_0300, 0);
        // R4: early OKAY disabled
        cfg_en = 1'b0;
        check_run("R4", 1, 1'b1, 3'd0, 1'b1, 32'h0000_0204, 0);
        check_run("R4", 4, 1'b1, 3'd3, 1'b1, 32'h0000_0200, 0);
        // R5: non-bufferable single
        check_run("R5", 1, 1'b1, 3'd0, 1'b0, 32'h0000_0204, 0);
        check_run("R5", 1, 1'b1, 3'd0, 1'b0, 32'h0000_0208, 0);

        // R6: every defined burst, every error position, three wait settings
        for (int w = 0; w < 3; w++) begin
            ws = w;
            for (int b = 2; b < 8; b++) begin
                for (int e = -1; e < blen(3'(b)); e++) begin
                    err_addr = (e < 0) ? 32'hFFFF_FFF0 : 32'h0000_1000 + 32'(4 * e);
                    check_run("R6", blen(3'(b)), 1'b1, 3'(b), 1'b0, 32'h0000_1000, 0);
                end
            end
        end
        ws = 1;
        // R7: undefined-length bursts, each beat its own response
        for (int e = -1; e < 5; e++) begin
            err_addr = (e < 0) ? 32'hFFFF_FFF0 : 32'h0000_2000 + 32'(4 * e);
            check_run("R7", 5, 1'b1, 3'd1, 1'b0, 32'h0000_2000, 0);
        end
        // R9: reads
        for (int e = -1; e < 4; e++) begin
            err_addr = (e < 0) ? 32'hFFFF_FFF0 : 32'h0000_3000 + 32'(4 * e);
            check_run("R9", 4, 1'b0, 3'd3, 1'b0, 32'h0000_3000, 0);
        end
        err_addr = 32'h0000_3100;
        check_run("R9", 1, 1'b0, 3'd0, 1'b1, 32'h0000_3100, 0);
        // R11: BUSY inside defined bursts
        for (int e = -1; e < 4; e++) begin
            err_addr = (e < 0) ? 32'hFFFF_FFF0 : 32'h0000_4000 + 32'(4 * e);
            for (int bb = 1; bb < 4; bb++) begin
                busy_wait = -1;
                check_run("R11", 4, 1'b1, 3'd3, 1'b0, 32'h0000_4000, bb);
                chk(busy_wait == 0, "R2", "BUSY data phase zero wait",
                    32'(busy_wait), 32'd0);
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
            $finish;
        end
    end

endmodule